// File: doc/BRIEF.md
# Audio Dual Baud-Rate Clock Generator

This block derives two audio bit-rate clocks from up to four reference clock inputs. One generator is meant for the 44.1 kHz sample-rate family and the other for the 48 kHz family. Each generator takes one reference through a source code. It divides that reference in two stages: a coarse power-of-four prescaler, then a fine (N+1) counter. The result is a single-cycle enable pulse once per division period. A single control bit chooses which generator drives the shared audio clock output.

Every serial port has its own 8-bit clock-select field. The field routes one raw reference, either generator, or nothing at all to that port's clock enable. Port 8 has no field of its own and always follows port 7. All logic runs on one system clock. Each reference clock arrives as a one-cycle tick already synchronised to that clock. Software programs the block through a simple write-only register port.

Top module: `audclk_top`

## Requirements
- R1: A divider word holds a prescale index in bits 9:8 and a fine value N in bits 7:0. The prescale ratio is 2, 8, 32 or 128 for index 0 to 3. One divider period spans ratio*(N+1) ticks of the selected source. The generator output is high for exactly one clock, on the clock after the tick that ends a period.
- R2: Reset state:
  - both divider words hold 2, which gives a division of 6;
  - the control word is 0, so both generators use source code 0 and generator A drives the shared output;
  - every port select is 0, and all outputs are low.
- R3: A divider write is held pending and replaces the running divider word only when a period ends. If the write lands in the same clock as that final tick, the written value governs the very next period.
- R4: Generator source codes are 0 = input A, 1 = input B, 2 = input I, 4 = input C. Any other code gives no ticks, and the generator's count is held. The reference tick vector is indexed A=0, B=1, C=2, I=3.
- R5: The control word is at address 0. Bit 31 set selects generator B for the shared output; bit 31 clear selects generator A. Bits 22:20 hold generator A's source code and bits 18:16 hold generator B's. All other bits of a write are ignored.
- R6: Port select codes are 0x01 = input A, 0x02 = input B, 0x03 = input C, 0x10 = generator A, 0x20 = generator B. Code 0x00, and any other value, holds that port's clock low. The field for port p is in bits (p%4)*8+7 down to (p%4)*8 of address 3+p/4.
- R7: Port 8 always carries the same clock as port 7. Its field slot (address 5, bits 7:0) is ignored.
- R8: Addresses 1 and 2 hold the divider words of generators A and B, and bits 31:10 of those writes are ignored. Writes to addresses 6 and 7 have no effect.
- R9: A port routed to a raw input follows that input's tick in the same clock. A port routed to a generator, and the shared output, follow that generator's pulse. Writes take effect from the clock after the write edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| refTick | input | 4 | Reference clock ticks (A, B, C, I) |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 3 | Register write address |
| wrData | input | 32 | Register write data |
| genTickA | output | 1 | Generator A pulse |
| genTickB | output | 1 | Generator B pulse |
| sharedTick | output | 1 | Shared audio clock output pulse |
| portTick | output | 10 | Per-serial-port clock enables |

## Verification
A divider write can land in the same clock as the source tick that ends a period, so reloading and reprogramming collide. The bench watches its model for a generator whose prescaler and fine counts both sit at their limits while the next tick for its source is about to be driven. About half the time it then issues a random divider write to that generator in that same cycle. It checks that the following period uses the freshly written word and not the old pending one, and it counts how often the collision was actually hit.

// File: rtl/audclk_pkg.sv
package audclk_pkg;
  parameter int REF_N      = 4;
  parameter int PORT_N     = 10;
  parameter int SHARE_PORT = 8;
  parameter int SHARE_SRC  = 7;
  parameter int SEL_W      = 8;
  parameter int PER_REG    = 4;
  parameter int ADDR_W     = 3;
  parameter int DATA_W     = 32;
  parameter int DIV_W      = 10;
  parameter int FINE_W     = 8;
  parameter int IDX_W      = 2;
  parameter int PRE_W      = 7;
  parameter int GEN_N      = 2;
  parameter int SRC_W      = 3;

  localparam int SEL_REGS = (PORT_N + PER_REG - 1) / PER_REG;

  localparam logic [ADDR_W-1:0] ADR_CTRL = 3'd0;
  localparam logic [ADDR_W-1:0] ADR_DIV0 = 3'd1;
  localparam logic [ADDR_W-1:0] ADR_SEL0 = 3'd3;

  localparam int CTRL_OUT_BIT = 31;
  localparam int SRCA_LSB     = 20;
  localparam int SRCB_LSB     = 16;
  localparam logic [DATA_W-1:0] CTRL_MASK = 32'h8077_0000;

  localparam logic [DIV_W-1:0] DIV_RESET = 10'd2;

  // reference tick vector positions
  localparam int REF_A = 0;
  localparam int REF_B = 1;
  localparam int REF_C = 2;
  localparam int REF_I = 3;

  typedef enum logic [SRC_W-1:0] {
    GSRC_A = 3'd0,
    GSRC_B = 3'd1,
    GSRC_I = 3'd2,
    GSRC_C = 3'd4
  } genSrc_e;

  typedef enum logic [SEL_W-1:0] {
    PSEL_OFF  = 8'h00,
    PSEL_A    = 8'h01,
    PSEL_B    = 8'h02,
    PSEL_C    = 8'h03,
    PSEL_GENA = 8'h10,
    PSEL_GENB = 8'h20
  } portSel_e;

  typedef struct packed {
    logic                ctrlWr;
    logic [GEN_N-1:0]    divWr;
    logic [SEL_REGS-1:0] selWr;
  } cfgStb_t;
endpackage

// File: rtl/audclk_gen.sv
module audclk_gen
  import audclk_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             srcTick,
  input  logic             wrStb,
  input  logic [DIV_W-1:0] wrVal,
  output logic             pulse
);
  logic [DIV_W-1:0]  activeQ;
  logic [DIV_W-1:0]  pendQ;
  logic [PRE_W-1:0]  preCnt;
  logic [FINE_W-1:0] fineCnt;
  logic [PRE_W:0]    preRatio;
  logic [PRE_W-1:0]  preLimit;
  logic              preLast;
  logic              fineLast;
  logic              periodEnd;

  assign preRatio  = (PRE_W+1)'(2) << {activeQ[DIV_W-1 -: IDX_W], 1'b0};
  assign preLimit  = PRE_W'(preRatio - 1'b1);
  assign preLast   = (preCnt == preLimit);
  assign fineLast  = (fineCnt == activeQ[FINE_W-1:0]);
  assign periodEnd = srcTick && preLast && fineLast;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendQ <= DIV_RESET;
    end else if (wrStb) begin
      pendQ <= wrVal;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      activeQ <= DIV_RESET;
      preCnt  <= '0;
      fineCnt <= '0;
      pulse   <= 1'b0;
    end else begin
      pulse <= periodEnd;
      if (srcTick) begin
        if (preLast) begin
          preCnt <= '0;
          if (fineLast) begin
            fineCnt <= '0;
            activeQ <= wrStb ? wrVal : pendQ;
          end else begin
            fineCnt <= fineCnt + 1'b1;
          end
        end else begin
          preCnt <= preCnt + 1'b1;
        end
      end
    end
  end

  // R1: prescaler count never passes its limit
  a_r1_pre_range: assert property (@(posedge clk) disable iff (!rstN)
    preCnt <= preLimit);

  // R1: a pulse always follows a source tick
  a_r1_pulse_after_tick: assert property (@(posedge clk) disable iff (!rstN)
    pulse |-> $past(srcTick));

  // R1: minimum division of 2 means pulses never touch
  a_r1_no_back_to_back: assert property (@(posedge clk) disable iff (!rstN)
    pulse |=> !pulse);

  // R3: running divider word only changes at a period end
  a_r3_update_at_end: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(activeQ) |-> $past(srcTick && preLast && fineLast));
endmodule

// File: rtl/audclk_ctrl.sv
module audclk_ctrl
  import audclk_pkg::*;
(
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  output cfgStb_t           stb,
  output logic [DATA_W-1:0] cfgData
);
  always_comb begin
    stb     = '0;
    cfgData = wrData;
    if (wrEn) begin
      if (wrAddr == ADR_CTRL) begin
        stb.ctrlWr = 1'b1;
        cfgData    = wrData & CTRL_MASK;
      end
      for (int g = 0; g < GEN_N; g++) begin
        if (wrAddr == ADR_DIV0 + ADDR_W'(g)) begin
          stb.divWr[g] = 1'b1;
        end
      end
      for (int r = 0; r < SEL_REGS; r++) begin
        if (wrAddr == ADR_SEL0 + ADDR_W'(r)) begin
          stb.selWr[r] = 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/audclk_dp.sv
module audclk_dp
  import audclk_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [REF_N-1:0]  refTick,
  input  cfgStb_t           stb,
  input  logic [DATA_W-1:0] cfgData,
  output logic [GEN_N-1:0]  genTick,
  output logic              sharedTick,
  output logic [PORT_N-1:0] portTick
);
  logic             outSelB;
  logic [SRC_W-1:0] genSrc [GEN_N];
  logic [PORT_N-1:0] portRaw;

  function automatic logic pickSource(input logic [SRC_W-1:0] code,
                                      input logic [REF_N-1:0] ticks);
    case (code)
      GSRC_A:  pickSource = ticks[REF_A];
      GSRC_B:  pickSource = ticks[REF_B];
      GSRC_I:  pickSource = ticks[REF_I];
      GSRC_C:  pickSource = ticks[REF_C];
      default: pickSource = 1'b0;
    endcase
  endfunction

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outSelB   <= 1'b0;
      genSrc[0] <= '0;
      genSrc[1] <= '0;
    end else if (stb.ctrlWr) begin
      outSelB   <= cfgData[CTRL_OUT_BIT];
      genSrc[0] <= cfgData[SRCA_LSB +: SRC_W];
      genSrc[1] <= cfgData[SRCB_LSB +: SRC_W];
    end
  end

  for (genvar g = 0; g < GEN_N; g++) begin : g_gen
    logic srcTick;
    assign srcTick = pickSource(genSrc[g], refTick);
    audclk_gen u_gen (
      .clk    (clk),
      .rstN   (rstN),
      .srcTick(srcTick),
      .wrStb  (stb.divWr[g]),
      .wrVal  (cfgData[DIV_W-1:0]),
      .pulse  (genTick[g])
    );
  end

  assign sharedTick = outSelB ? genTick[1] : genTick[0];

  for (genvar p = 0; p < PORT_N; p++) begin : g_port
    localparam int REG_I = p / PER_REG;
    localparam int LSB   = (p % PER_REG) * SEL_W;
    if (p == SHARE_PORT) begin : g_shared
      assign portRaw[p]  = 1'b0;
      assign portTick[p] = portRaw[SHARE_SRC];
    end else begin : g_own
      logic [SEL_W-1:0] selQ;
      always_ff @(posedge clk) begin
        if (!rstN) begin
          selQ <= PSEL_OFF;
        end else if (stb.selWr[REG_I]) begin
          selQ <= cfgData[LSB +: SEL_W];
        end
      end
      always_comb begin
        case (selQ)
          PSEL_A:    portRaw[p] = refTick[REF_A];
          PSEL_B:    portRaw[p] = refTick[REF_B];
          PSEL_C:    portRaw[p] = refTick[REF_C];
          PSEL_GENA: portRaw[p] = genTick[0];
          PSEL_GENB: portRaw[p] = genTick[1];
          default:   portRaw[p] = 1'b0;
        endcase
      end
      assign portTick[p] = portRaw[p];
      // R6: a port clock is only ever a live tick or pulse
      a_r6_port_has_source: assert property (@(posedge clk) disable iff (!rstN)
        portTick[p] |-> ((|refTick) || (|genTick)));
    end
  end
endmodule

// File: rtl/audclk_top.sv
module audclk_top
  import audclk_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [REF_N-1:0]  refTick,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  output logic              genTickA,
  output logic              genTickB,
  output logic              sharedTick,
  output logic [PORT_N-1:0] portTick
);
  cfgStb_t           stb;
  logic [DATA_W-1:0] cfgData;
  logic [GEN_N-1:0]  genTick;

  audclk_ctrl u_ctrl (
    .wrEn   (wrEn),
    .wrAddr (wrAddr),
    .wrData (wrData),
    .stb    (stb),
    .cfgData(cfgData)
  );

  audclk_dp u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .refTick   (refTick),
    .stb       (stb),
    .cfgData   (cfgData),
    .genTick   (genTick),
    .sharedTick(sharedTick),
    .portTick  (portTick)
  );

  assign genTickA = genTick[0];
  assign genTickB = genTick[1];

  // R5: the shared output only pulses with one of the generators
  a_r5_shared_from_gen: assert property (@(posedge clk) disable iff (!rstN)
    sharedTick |-> (genTickA || genTickB));

  // R7: port 8 mirrors port 7 on every clock
  a_r7_port_mirror: assert property (@(posedge clk) disable iff (!rstN)
    portTick[SHARE_PORT] == portTick[SHARE_SRC]);
endmodule

// File: tb/sim_audclk_top.sv
`timescale 1ns/1ps
module sim_audclk_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [3:0]  refTick = '0;
  logic        wrEn = 1'b0;
  logic [2:0]  wrAddr = '0;
  logic [31:0] wrData = '0;
  logic        genTickA, genTickB, sharedTick;
  logic [9:0]  portTick;

  audclk_top u0 (
    .clk(clk), .rstN(rstN), .refTick(refTick), .wrEn(wrEn),
    .wrAddr(wrAddr), .wrData(wrData), .genTickA(genTickA),
    .genTickB(genTickB), .sharedTick(sharedTick), .portTick(portTick)
  );

  always #4 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // model state
  int mAct[2], mPend[2], mPre[2], mFine[2], mSrc[2];
  bit mPulse[2];
  bit mOutB;
  int mSel[10];
  int hitCount = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int ratioOf(input int d);
    return 2 << (2 * ((d >> 8) & 3));
  endfunction

  function automatic bit srcBit(input int code, input bit [3:0] rt);
    case (code)
      0: return rt[0];
      1: return rt[1];
      2: return rt[3];
      4: return rt[2];
      default: return 1'b0;
    endcase
  endfunction

  function automatic bit portExp(input int p, input bit [3:0] rt);
    int q = (p == 8) ? 7 : p;
    case (mSel[q])
      8'h01: return rt[0];
      8'h02: return rt[1];
      8'h03: return rt[2];
      8'h10: return mPulse[0];
      8'h20: return mPulse[1];
      default: return 1'b0;
    endcase
  endfunction

  function automatic bit atEnd(input int g, input bit [3:0] rt);
    return srcBit(mSrc[g], rt) && (mPre[g] == ratioOf(mAct[g]) - 1)
           && (mFine[g] == (mAct[g] & 255));
  endfunction

  task automatic modelReset();
    for (int g = 0; g < 2; g++) begin
      mAct[g] = 2; mPend[g] = 2; mPre[g] = 0; mFine[g] = 0;
      mSrc[g] = 0; mPulse[g] = 0;
    end
    mOutB = 0;
    for (int p = 0; p < 10; p++) mSel[p] = 0;
  endtask

  task automatic modelStep(input bit [3:0] rt, input bit we, input int addr, input int data);
    for (int g = 0; g < 2; g++) begin
      bit wr = we && (addr == 1 + g);
      int nv = data & 32'h3FF;
      mPulse[g] = 0;
      if (srcBit(mSrc[g], rt)) begin
        if (mPre[g] == ratioOf(mAct[g]) - 1) begin
          mPre[g] = 0;
          if (mFine[g] == (mAct[g] & 255)) begin
            mFine[g] = 0;
            mAct[g] = wr ? nv : mPend[g];
            mPulse[g] = 1;
          end else mFine[g]++;
        end else mPre[g]++;
      end
      if (wr) mPend[g] = nv;
    end
    if (we && addr == 0) begin
      mOutB = data[31];
      mSrc[0] = (data >> 20) & 7;
      mSrc[1] = (data >> 16) & 7;
    end
    if (we && addr >= 3 && addr <= 5) begin
      for (int f = 0; f < 4; f++) begin
        int p = (addr - 3) * 4 + f;
        if (p < 10 && p != 8) mSel[p] = (data >> (f * 8)) & 255;
      end
    end
  endtask

  function automatic int pickCode();
    case ($urandom % 8)
      0: return 8'h00;
      1: return 8'h01;
      2: return 8'h02;
      3: return 8'h03;
      4: return 8'h10;
      5: return 8'h20;
      default: return $urandom % 256;
    endcase
  endfunction

  function automatic int pickDiv();
    int idx = (($urandom % 8) == 0) ? 2 : ($urandom % 2);
    int fine = $urandom % 6;
    return ($urandom & 32'hFFFF_FC00) | (idx << 8) | fine;
  endfunction

  task automatic checkOutputs(input bit [3:0] rt);
    bit [9:0] pe;
    bit se;
    chk(genTickA == mPulse[0], "R1 R3 R4 genTickA", genTickA, mPulse[0]);
    chk(genTickB == mPulse[1], "R1 R3 R4 genTickB", genTickB, mPulse[1]);
    se = mOutB ? mPulse[1] : mPulse[0];
    chk(sharedTick == se, "R5 sharedTick", sharedTick, se);
    for (int p = 0; p < 10; p++) pe[p] = portExp(p, rt);
    chk(portTick == pe, "R6 R8 R9 portTick", portTick, pe);
    chk(portTick[8] == portTick[7], "R7 port8 mirror", portTick[8], portTick[7]);
  endtask

  initial begin
    bit [3:0] rt;
    bit we;
    int addr, data, lastA, gapErr;
    void'($urandom(32'd1234));
    modelReset();
    repeat (3) @(negedge clk);
    #1;
    // R2: reset state
    chk(genTickA == 0 && genTickB == 0 && sharedTick == 0, "R2 gen reset", {genTickA, genTickB, sharedTick}, 0);
    chk(portTick == 0, "R2 ports reset", portTick, 0);
    rstN = 1'b1;
    rt = 0; we = 0; addr = 0; data = 0;
    lastA = -1; gapErr = 0;
    for (int cyc = 0; cyc < 20000; cyc++) begin
      @(negedge clk);
      modelStep(rt, we, addr, data);
      if (cyc < 200) begin
        rt = 4'b1111; we = 0; addr = 0; data = 0;
      end else begin
        rt = 4'($urandom);
        if (($urandom % 4) == 0) rt = 4'b1111;
        we = (($urandom % 8) == 0);
        addr = $urandom % 8;
        case (addr)
          0: data = $urandom;
          1, 2: data = pickDiv();
          3, 4, 5: data = {8'(pickCode()), 8'(pickCode()), 8'(pickCode()), 8'(pickCode())};
          default: data = $urandom;
        endcase
        // R3: collide a divider write with a period end
        for (int g = 0; g < 2; g++) begin
          if (atEnd(g, rt) && ($urandom % 2 == 0)) begin
            we = 1; addr = 1 + g; data = pickDiv(); hitCount++;
          end
        end
      end
      refTick = rt; wrEn = we; wrAddr = 3'(addr); wrData = data;
      #1;
      checkOutputs(rt);
      if (cyc < 200 && genTickA) begin
        // R2: default division of 6 on continuous input A ticks
        if (lastA >= 0) chk(cyc - lastA == 6, "R2 default period", cyc - lastA, 6);
        lastA = cyc;
      end
    end
    chk(hitCount > 0, "R3 collision reached", hitCount, 1);
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule